// File: doc/BRIEF.md
# Pseudo-Static RAM Cycle Sequencer

This block sits between a synchronous request source and an asynchronous byte-wide pseudo-static RAM. It turns one accepted request into one correctly ordered strobe sequence on the active-low chip enable, output enable and write enable pins. Three request kinds are served: a single read, a single write, and a combined read-modify-write in which the old byte is sensed, the bus is turned around, and a new byte is written back under the same chip-enable low period. The combined form saves one precharge gap and one address phase compared with a separate read followed by a separate write.

Every timing interval is a parameter counted in system clock cycles. The defaults are access 10, random cycle 16, precharge 5, turnaround 3, write pulse 8 and read-modify-write cycle 24. The RAM latches its address on the falling edge of chip enable. The sequencer therefore shows the requested address while it is idle, registers the address on acceptance, and holds it until chip enable has risen again. The bus towards the RAM is split into an outgoing byte, a drive-enable and an incoming byte.

The state machine has the states IDLE, RD_SENSE, WR_STROBE, WR_HOLD, MX_SENSE, MX_TURN, MX_STROBE, MX_HOLD and PRECHG. It moves through them as follows:
- IDLE goes to RD_SENSE, WR_STROBE or MX_SENSE on acceptance, according to the operation code.
- RD_SENSE goes to PRECHG when the access count ends.
- WR_STROBE goes to WR_HOLD when the write-pulse count ends, and WR_HOLD goes to PRECHG after one cycle.
- MX_SENSE goes to MX_TURN when the access count ends.
- MX_TURN goes to MX_STROBE when the turnaround count ends.
- MX_STROBE goes to MX_HOLD when the write-pulse count ends, and MX_HOLD goes to PRECHG after one cycle.
- PRECHG goes to IDLE once both the precharge and the minimum-cycle limits allow the next chip-enable fall.

Top module: `psram_seq_ctrl`

## Requirements
- R1: While reset is held low, chip enable, output enable and write enable are high, the drive-enable is low, `rsp_done` is low and `req_ready` is high.
- R2: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. Chip enable goes low in the very next cycle. `ram_addr` shows `req_addr` while idle, and from acceptance it holds the accepted address until chip enable has risen. Operation codes are: 00 read, 01 write, 10 modify by adding, 11 modify by XOR.
- R3: A read holds chip enable and output enable low for exactly T_ACC cycles. The byte on `ram_dq_i` is captured at the clock edge that ends the T_ACC-th cycle. That byte appears on `rsp_rdata` during the `rsp_done` cycle.
- R4: A write holds write enable low for the first T_WP cycles of chip enable low, followed by one cycle with write enable high and chip enable still low. The byte is driven during all T_WP+1 cycles, and output enable stays high.
- R5: A modify request holds output enable low for T_ACC cycles. Then come T_TA cycles with both strobes high and the bus undriven, then T_WP cycles of write enable low with the bus driven, then one hold cycle. Chip enable stays low for T_ACC+T_TA+T_WP+1 cycles, and `rsp_rdata` returns the old byte.
- R6: The byte written back by a modify request is the old byte plus the request byte, modulo 256, for code 10, and the old byte XOR the request byte for code 11.
- R7: The bus is never driven while output enable is low. Output enable and write enable are never low together, and write enable is low only while chip enable is low.
- R8: Chip enable stays high for at least T_PRE cycles between two low periods.
- R9: `req_ready` returns in the first cycle from which an acceptance gives a chip-enable fall that meets both limits: at least T_PRE cycles high, and at least T_CYC cycles after the previous fall (T_RMW if that access was a modify).
- R10: `req_valid` with any operation code, address or data while `req_ready` is low is ignored: no strobe, address or ready timing changes.
- R11: `rsp_done` is a single-cycle pulse per request, in the first cycle after chip enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 2 | Operation code (see R2) |
| req_addr | input | AW | Byte address |
| req_wdata | input | 8 | Write byte or modify operand |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte sensed by a read or modify request |
| ram_addr | output | AW | Address pins of the RAM |
| ram_ce_n | output | 1 | Chip enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_dq_o | output | 8 | Byte driven towards the RAM |
| ram_dq_oe | output | 1 | Drive-enable for `ram_dq_o` |
| ram_dq_i | input | 8 | Byte returned by the RAM |

## Verification
The precharge limit and the minimum fall-to-fall limit both gate the PRECHG exit, and the two counts can run out in the same cycle. Which one ends last depends on the kind of the previous access: the cycle limit binds after a read or a write, and the precharge limit binds after a modify. The bench offers requests back to back, with a garbage request shown during every busy cycle, so that acceptance lands on the first permitted cycle. A reference schedule computed from R8 and R9 then judges the exact cycle in which `req_ready` returns. A behavioural RAM with its own interval timers checks each fall independently.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'b00,
        OP_WRITE   = 2'b01,
        OP_MIX_ADD = 2'b10,
        OP_MIX_XOR = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_SENSE,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_MX_SENSE,
        ST_MX_TURN,
        ST_MX_STROBE,
        ST_MX_HOLD,
        ST_PRECHG
    } st_e;

    function automatic logic is_mix(op_e op);
        return op[1];
    endfunction

    // new byte formed from the sensed byte and the request operand
    function automatic logic [7:0] mix_byte(op_e op, logic [7:0] old_b, logic [7:0] opnd);
        if (op == OP_MIX_XOR) return old_b ^ opnd;
        return old_b + opnd;
    endfunction

endpackage

// File: rtl/psram_span_cnt.sv
module psram_span_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (clr)       q <= '0;
        else if (q != '1)   q <= q + 1'b1;
    end
endmodule

// File: rtl/psram_dpath.sv
module psram_dpath
    import psram_seq_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          sense_end,
    input  logic          bypass,
    input  logic [AW-1:0] req_addr,
    input  op_e           req_op,
    input  logic [7:0]    req_wdata,
    input  logic [7:0]    ram_dq_i,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_dq_o,
    output logic [7:0]    rd_data,
    output op_e           op_q
);
    logic [AW-1:0] addr_q;
    logic [7:0]    opnd_q;
    logic [7:0]    wd_q;
    logic [7:0]    rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            op_q   <= OP_READ;
            opnd_q <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
        end else begin
            if (load) begin
                addr_q <= req_addr;
                op_q   <= req_op;
                opnd_q <= req_wdata;
                wd_q   <= req_wdata;
            end
            if (sense_end) begin
                rd_q <= ram_dq_i;
                if (is_mix(op_q)) wd_q <= mix_byte(op_q, ram_dq_i, opnd_q);
            end
        end
    end

    assign ram_addr = bypass ? req_addr : addr_q;
    assign ram_dq_o = wd_q;
    assign rd_data  = rd_q;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && $past(!bypass)) |-> $stable(ram_addr)) else $error("address moved"); // R2
endmodule

// File: rtl/psram_seq_ctrl.sv
module psram_seq_ctrl
    import psram_seq_pkg::*;
#(
    parameter int AW    = 17,
    parameter int T_ACC = 10,
    parameter int T_CYC = 16,
    parameter int T_PRE = 5,
    parameter int T_TA  = 3,
    parameter int T_WP  = 8,
    parameter int T_RMW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_wdata,
    output logic          rsp_done,
    output logic [7:0]    rsp_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_ce_n,
    output logic          ram_oe_n,
    output logic          ram_we_n,
    output logic [7:0]    ram_dq_o,
    output logic          ram_dq_oe,
    input  logic [7:0]    ram_dq_i
);
    localparam int SPAN_TOP = T_ACC + T_TA + T_WP + T_RMW + T_CYC + T_PRE + 4;
    localparam int CW       = $clog2(SPAN_TOP + 1);
    localparam logic [CW-1:0] K_ACC_END  = CW'(T_ACC - 1);
    localparam logic [CW-1:0] K_WP_END   = CW'(T_WP - 1);
    localparam logic [CW-1:0] K_TA_END   = CW'(T_ACC + T_TA - 1);
    localparam logic [CW-1:0] K_MXW_END  = CW'(T_ACC + T_TA + T_WP - 1);
    localparam logic [CW-1:0] K_PRE_OK   = CW'(T_PRE - 2);
    localparam logic [CW-1:0] K_CYC_OK   = CW'(T_CYC - 2);
    localparam logic [CW-1:0] K_RMW_OK   = CW'(T_RMW - 2);

    st_e           st_q, st_d;
    op_e           op_q;
    logic [CW-1:0] span;
    logic [CW-1:0] gap;
    logic          accept, sense_end, enter_pre, gap_ok;

    assign accept    = req_valid && req_ready;
    assign enter_pre = (st_d == ST_PRECHG) && (st_q != ST_PRECHG);
    assign sense_end = ((st_q == ST_RD_SENSE) || (st_q == ST_MX_SENSE)) && (span == K_ACC_END);
    assign gap_ok    = (gap >= K_PRE_OK) && (span >= (is_mix(op_q) ? K_RMW_OK : K_CYC_OK));

    // cycles since chip enable fell
    psram_span_cnt #(.W(CW)) u_span (.clk(clk), .rst_n(rst_n), .clr(accept), .q(span));
    // cycles since chip enable rose
    psram_span_cnt #(.W(CW)) u_gap (.clk(clk), .rst_n(rst_n), .clr(enter_pre), .q(gap));

    psram_dpath #(.AW(AW)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .sense_end (sense_end),
        .bypass    (st_q == ST_IDLE),
        .req_addr  (req_addr),
        .req_op    (op_e'(req_op)),
        .req_wdata (req_wdata),
        .ram_dq_i  (ram_dq_i),
        .ram_addr  (ram_addr),
        .ram_dq_o  (ram_dq_o),
        .rd_data   (rsp_rdata),
        .op_q      (op_q)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) begin
                unique case (op_e'(req_op))
                    OP_READ:  st_d = ST_RD_SENSE;
                    OP_WRITE: st_d = ST_WR_STROBE;
                    default:  st_d = ST_MX_SENSE;
                endcase
            end
            ST_RD_SENSE:  if (span == K_ACC_END) st_d = ST_PRECHG;
            ST_WR_STROBE: if (span == K_WP_END)  st_d = ST_WR_HOLD;
            ST_WR_HOLD:   st_d = ST_PRECHG;
            ST_MX_SENSE:  if (span == K_ACC_END) st_d = ST_MX_TURN;
            ST_MX_TURN:   if (span == K_TA_END)  st_d = ST_MX_STROBE;
            ST_MX_STROBE: if (span == K_MXW_END) st_d = ST_MX_HOLD;
            ST_MX_HOLD:   st_d = ST_PRECHG;
            ST_PRECHG:    if (gap_ok) st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            rsp_done <= 1'b0;
        end else begin
            st_q     <= st_d;
            rsp_done <= enter_pre;
        end
    end

    always_comb begin
        ram_ce_n  = 1'b0;
        ram_oe_n  = 1'b1;
        ram_we_n  = 1'b1;
        ram_dq_oe = 1'b0;
        req_ready = 1'b0;
        unique case (st_q)
            ST_IDLE:      begin ram_ce_n = 1'b1; req_ready = 1'b1; end
            ST_RD_SENSE,
            ST_MX_SENSE:  ram_oe_n = 1'b0;
            ST_WR_STROBE,
            ST_MX_STROBE: begin ram_we_n = 1'b0; ram_dq_oe = 1'b1; end
            ST_WR_HOLD,
            ST_MX_HOLD:   ram_dq_oe = 1'b1;
            ST_MX_TURN:   ;
            ST_PRECHG:    ram_ce_n = 1'b1;
            default:      ram_ce_n = 1'b1;
        endcase
    end

    AST_BUS_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_dq_oe && !ram_oe_n)) else $error("bus contention"); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_oe_n && !ram_we_n)) else $error("both strobes low"); // R7
    AST_WE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> !ram_ce_n) else $error("write outside select"); // R7
    AST_FALL_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_ce_n) |-> $past(req_valid && req_ready)) else $error("fall without accept"); // R2
    AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $rose(ram_ce_n)) else $error("done misplaced"); // R11
    AST_PRE_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_ce_n) |=> ram_ce_n) else $error("precharge too short"); // R8
endmodule

// File: tb/psram_seq_ctrl_tb.sv
module psram_seq_ctrl_tb;
    localparam int AW = 8, TACC = 10, TCYC = 16, TPRE = 5, TTA = 3, TWP = 8, TRMW = 24;
    localparam int NREQ = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic rsp_done;
    logic [7:0] rsp_rdata;
    logic [AW-1:0] ram_addr;
    logic ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [7:0] ram_dq_o;
    logic [7:0] ram_dq_i = 8'hA5;

    always #10 clk = ~clk;

    psram_seq_ctrl #(.AW(AW), .T_ACC(TACC), .T_CYC(TCYC), .T_PRE(TPRE), .T_TA(TTA),
                     .T_WP(TWP), .T_RMW(TRMW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
        .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i));

    int n_cmp = 0, n_bad = 0;
    logic [7:0] mem [256];
    logic [7:0] sb  [256];
    int q_op [NREQ], q_adr [NREQ], q_wd [NREQ], q_gap [NREQ];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int len_of(int op);
        if (op == 0) return TACC;
        if (op == 1) return TWP + 1;
        return TACC + TTA + TWP + 1;
    endfunction

    function automatic logic [3:0] exp_strobe(int op, int d);
        logic ce_lo, oe_lo, we_lo, drv;
        int l = len_of(op);
        ce_lo = (d >= 0) && (d < l);
        oe_lo = (op != 1) && (d >= 0) && (d < TACC);
        if (op == 1) begin
            we_lo = (d >= 0) && (d < TWP);
            drv   = ce_lo;
        end else begin
            we_lo = (op >= 2) && (d >= TACC + TTA) && (d < TACC + TTA + TWP);
            drv   = (op >= 2) && (d >= TACC + TTA) && (d < l);
        end
        return {!ce_lo, !oe_lo, !we_lo, drv};
    endfunction

    function automatic string op_tag(int op);
        if (op == 0) return "R3";
        if (op == 1) return "R4";
        return "R5";
    endfunction

    initial begin
        int c, qi, gap, idle_start, cur_fall, cur_op, cur_adr, cur_rexp, cur_wexp;
        bit garbage_prev, done_loop;
        logic prev_ce, prev_oe, prev_we, prev_dq;
        int last_fall, last_rise, last_tmin, ram_t, oe_rise_c;
        logic [7:0] lat_addr;
        bit oe_used, mx;
        bit img_ok;

        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            sb[i]  = 8'(i * 7 + 3);
        end
        // op, address, byte, idle cycles before offering
        q_op[0]=0;  q_adr[0]=8'h10;  q_wd[0]=8'h00; q_gap[0]=0;
        q_op[1]=1;  q_adr[1]=8'h10;  q_wd[1]=8'h5A; q_gap[1]=0;
        q_op[2]=0;  q_adr[2]=8'h10;  q_wd[2]=8'h00; q_gap[2]=3;
        q_op[3]=2;  q_adr[3]=8'h10;  q_wd[3]=8'h03; q_gap[3]=0;
        q_op[4]=0;  q_adr[4]=8'h10;  q_wd[4]=8'h00; q_gap[4]=0;
        q_op[5]=3;  q_adr[5]=8'hFF;  q_wd[5]=8'hF0; q_gap[5]=2;
        q_op[6]=0;  q_adr[6]=8'hFF;  q_wd[6]=8'h00; q_gap[6]=0;
        q_op[7]=1;  q_adr[7]=8'h00;  q_wd[7]=8'hC3; q_gap[7]=0;
        q_op[8]=2;  q_adr[8]=8'h00;  q_wd[8]=8'h40; q_gap[8]=0;
        q_op[9]=0;  q_adr[9]=8'h00;  q_wd[9]=8'h00; q_gap[9]=0;
        q_op[10]=3; q_adr[10]=8'h80; q_wd[10]=8'hFF; q_gap[10]=5;
        q_op[11]=1; q_adr[11]=8'h81; q_wd[11]=8'h11; q_gap[11]=0;
        q_op[12]=2; q_adr[12]=8'h81; q_wd[12]=8'hFF; q_gap[12]=0;
        q_op[13]=0; q_adr[13]=8'h81; q_wd[13]=8'h00; q_gap[13]=0;
        q_op[14]=0; q_adr[14]=8'h80; q_wd[14]=8'h00; q_gap[14]=1;

        repeat (3) @(negedge clk);
        chk(ram_ce_n === 1'b1, "R1", "ce_n in reset", ram_ce_n, 1);
        chk(ram_oe_n === 1'b1 && ram_we_n === 1'b1, "R1", "oe_n/we_n in reset", {ram_oe_n, ram_we_n}, 3);
        chk(ram_dq_oe === 1'b0, "R1", "drive in reset", ram_dq_oe, 0);
        chk(rsp_done === 1'b0, "R1", "done in reset", rsp_done, 0);
        chk(req_ready === 1'b1, "R1", "ready in reset", req_ready, 1);
        rst_n = 1'b1;

        c = -1; qi = 0; gap = q_gap[0]; idle_start = 0; cur_fall = -1000; cur_op = 0;
        cur_adr = 0; cur_rexp = 0; cur_wexp = 0; garbage_prev = 0; done_loop = 0;
        prev_ce = 1; prev_oe = 1; prev_we = 1; prev_dq = 0;
        last_fall = -1000; last_rise = -1000; last_tmin = 0; ram_t = 0; oe_rise_c = -1000;
        lat_addr = '0; oe_used = 0; mx = 0;

        while (!done_loop) begin
            logic [3:0] es;
            bit exp_ready;
            int d;
            @(negedge clk);
            c++;
            if (c > 20000) begin
                chk(1'b0, "R2", "watchdog expired", c, 0);
                break;
            end
            d = c - cur_fall;
            es = exp_strobe(cur_op, d);
            exp_ready = (c >= idle_start);

            // reference schedule comparison
            chk({ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe} === es,
                garbage_prev ? "R10" : op_tag(cur_op), "strobes", {ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe}, es);
            chk(req_ready === exp_ready, garbage_prev ? "R10" : "R9", "ready", req_ready, exp_ready);
            chk(rsp_done === (d == len_of(cur_op)), "R11", "done", rsp_done, d == len_of(cur_op));
            chk(!(ram_dq_oe && !ram_oe_n), "R7", "bus driven under oe", ram_dq_oe, 0);
            if (!ram_ce_n) chk(ram_addr == AW'(cur_adr), "R2", "address held", ram_addr, cur_adr);
            if (d == len_of(cur_op) && cur_op != 1)
                chk(rsp_rdata == 8'(cur_rexp), cur_op == 0 ? "R3" : "R5", "read byte", rsp_rdata, cur_rexp);

            // behavioural RAM with interval timers
            if (prev_ce && !ram_ce_n) begin
                chk(c - last_fall >= last_tmin, "R9", "fall-to-fall", c - last_fall, last_tmin);
                chk(c - last_rise >= TPRE, "R8", "precharge", c - last_rise, TPRE);
                last_fall = c; lat_addr = ram_addr; ram_t = 0; oe_used = 0; mx = 0;
            end else if (!ram_ce_n) begin
                ram_t++;
            end
            if (!prev_ce && ram_ce_n) begin
                last_rise = c;
                last_tmin = mx ? TRMW : TCYC;
            end
            if (!ram_ce_n && !ram_oe_n) oe_used = 1;
            if (!prev_oe && ram_oe_n) oe_rise_c = c;
            if (!ram_ce_n && !ram_we_n && oe_used) mx = 1;
            if (!prev_dq && ram_dq_oe && oe_used)
                chk(c - oe_rise_c >= TTA, "R5", "turnaround", c - oe_rise_c, TTA);
            if (!prev_we && ram_we_n) begin
                chk(!ram_ce_n && ram_dq_oe, "R4", "write hold", {ram_ce_n, ram_dq_oe}, 1);
                chk(ram_dq_o == 8'(cur_wexp), cur_op == 1 ? "R4" : "R6", "written byte", ram_dq_o, cur_wexp);
                mem[lat_addr] = ram_dq_o;
            end
            prev_ce = ram_ce_n; prev_oe = ram_oe_n; prev_we = ram_we_n; prev_dq = ram_dq_oe;
            ram_dq_i = (!ram_ce_n && !ram_oe_n && ram_t >= TACC - 1) ? mem[lat_addr] : 8'hA5;

            // request driver
            garbage_prev = 0;
            if (qi < NREQ && gap > 0) begin
                gap--;
                req_valid = 1'b0;
            end else if (qi < NREQ && !exp_ready) begin
                req_valid = 1'b1;
                req_op    = 2'(3 - q_op[qi]);
                req_addr  = ~AW'(q_adr[qi]);
                req_wdata = ~8'(q_wd[qi]);
                garbage_prev = 1;
            end else if (qi < NREQ) begin
                req_valid = 1'b1;
                req_op    = 2'(q_op[qi]);
                req_addr  = AW'(q_adr[qi]);
                req_wdata = 8'(q_wd[qi]);
                cur_fall = c + 1;
                cur_op   = q_op[qi];
                cur_adr  = q_adr[qi];
                cur_rexp = sb[cur_adr];
                if (cur_op == 1) cur_wexp = q_wd[qi];
                else if (cur_op == 2) cur_wexp = 8'(sb[cur_adr] + 8'(q_wd[qi]));
                else if (cur_op == 3) cur_wexp = sb[cur_adr] ^ 8'(q_wd[qi]);
                if (cur_op != 0) sb[cur_adr] = 8'(cur_wexp);
                idle_start = cur_fall + ((len_of(cur_op) + TPRE - 1) > ((cur_op >= 2 ? TRMW : TCYC) - 1)
                             ? (len_of(cur_op) + TPRE - 1) : ((cur_op >= 2 ? TRMW : TCYC) - 1));
                qi++;
                if (qi < NREQ) gap = q_gap[qi];
            end else begin
                req_valid = 1'b0;
                if (c >= idle_start + 2) done_loop = 1;
            end
        end

        img_ok = 1;
        for (int i = 0; i < 256; i++) if (mem[i] !== sb[i]) img_ok = 0;
        chk(img_ok, "R6", "final memory image", img_ok, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule